// File: doc/BRIEF.md
# Serial EEPROM Write Guard and Status Register

This block decides whether a 512-byte serial EEPROM may be written. It holds the state that governs that decision: the write enable latch, the two block-protect bits and the busy flag. It also runs the self-timed write cycle. An upstream command decoder does all serial shifting. It hands this block single-cycle strobes, the chip-select level, the hardware protect pin and the target address of a page write.

Each status-write or array-write commit gets a registered verdict in the next cycle, either `grant` or `deny`. A granted commit starts an internal write cycle. That cycle lasts a fixed number of system clocks, and `busy` stays high for its whole length. The status byte is driven from registers on every cycle, so the host may poll it at any time, including during a write cycle.

A power-on reset puts the block in its shipping state. A soft reset keeps the protect bits, which models storage that survives a reset.

Top module: `eeprom_wprot_ctrl`

## Requirements
- R1: `status_byte` is, from MSB to LSB: four zero bits, BP1 (bit 3), BP0 (bit 2), the enable latch (bit 1) and busy (bit 0). It reflects the registers in every cycle, busy included.
- R2: `por` (synchronous, active high) clears the latch, both protect bits and busy. `soft_rst` clears only the latch and any armed enable: the protect bits keep their value and a running write cycle continues.
- R3: A `wren_done` strobe arms the enable. The latch is set in the cycle after `cs_n` goes from 0 to 1, and only if the enable was armed. While `cs_n` stays low the latch stays clear.
- R4: A `wrdi` strobe clears the latch in the next cycle, whatever the protect bits hold.
- R5: While `wp_n` is 0 the latch is held at 0, and every commit is answered with `deny`.
- R6: For an array write, the protect bits lock these addresses: 00 locks none, 01 locks 0x180..0x1FF, 10 locks 0x100..0x1FF and 11 locks every address. A commit to a locked address is denied.
- R7: An array commit made while idle, with `wp_n`=1, the latch set and an unlocked address, is granted. The cycle after the commit shows `grant`, the latch cleared and busy set. A denied commit pulses `deny` and leaves the latch unchanged.
- R8: A status commit made while idle, with `wp_n`=1 and the latch set, is granted whatever the protect bits hold. It loads BP1:BP0 from `wrsr_data[3:2]`, clears the latch and starts a write cycle. The protect bits change on no other event except `por`.
- R9: After a grant, busy stays high for exactly CYCLE_CLKS cycles, counting the grant cycle. Pulling `wp_n` low during the cycle does not shorten it.
- R10: A commit that arrives while busy is ignored: no `grant`, no `deny`, and no change to the protect bits or the latch.
- R11: When a clearing event (`wrdi`, a grant, `soft_rst`, `wp_n`=0) falls in the same cycle as an enabling chip-select rise, the latch ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, keeps the protect bits |
| wp_n | input | 1 | Hardware write protect, active low |
| cs_n | input | 1 | Chip-select level, active low |
| wren_done | input | 1 | Strobe: a complete write-enable command was received |
| wrdi | input | 1 | Strobe: write-disable command |
| wrsr_commit | input | 1 | Strobe: status-write frame completed |
| wrsr_data | input | 8 | Status byte written by the host |
| write_commit | input | 1 | Strobe: array-write frame completed |
| write_addr | input | ADDR_W | Address of the page being written |
| status_byte | output | 8 | Status register contents |
| grant | output | 1 | One-cycle pulse: commit accepted |
| deny | output | 1 | One-cycle pulse: commit refused |
| busy | output | 1 | Internal write cycle running |

## Verification
Some properties are checked by assertions on every cycle:
- The latch is clear after any cycle in which `wp_n` was low.
- The latch can only rise right after a chip-select rise.
- `grant` and `deny` never pulse together.
- Every grant is accompanied by a cleared latch and a busy flag.
- The protect bits are stable unless a status write was accepted.
- The timer is never restarted while busy.

Other behaviours only the bench's scenarios can show:
- The exact length of the write cycle, and that a protect-pin fall does not shorten it.
- The address boundaries of each protect level.
- Which resets keep the protect bits.
- That commits made while busy leave the state untouched.
- Which event wins when a set and a clear of the latch fall in the same cycle.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    // Protection level held in the two protect bits of the status byte.
    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_lvl_e;

    // Status byte as seen by the host, MSB first.
    typedef struct packed {
        logic [3:0] spare;
        prot_lvl_e  lvl;
        logic       wel;
        logic       wip;
    } status_t;

    // Verdict for a commit strobe.
    typedef struct packed {
        logic acc_wr;
        logic acc_sr;
        logic rej;
    } verdict_t;

    localparam int STAT_LVL_LSB = 2;

    // A locked region always starts on a quarter boundary, so the two top
    // address bits are enough to decide.
    function automatic logic region_locked(prot_lvl_e lvl, logic [1:0] top2);
        logic hit;
        unique case (lvl)
            PROT_NONE:    hit = 1'b0;
            PROT_QUARTER: hit = (top2 == 2'b11);
            PROT_HALF:    hit = top2[1];
            default:      hit = 1'b1;
        endcase
        return hit;
    endfunction

    function automatic status_t pack_status(prot_lvl_e lvl, logic wel, logic wip);
        status_t s;
        s.spare = '0;
        s.lvl   = lvl;
        s.wel   = wel;
        s.wip   = wip;
        return s;
    endfunction

endpackage

// File: rtl/wprot_enable_latch.sv
module wprot_enable_latch (
    input  logic clk,
    input  logic por,
    input  logic soft_rst,
    input  logic wp_n,
    input  logic cs_n,
    input  logic wren_done,
    input  logic wrdi,
    input  logic consume,
    output logic wel
);

    logic cs_q;
    logic armed;
    logic cs_rise;
    logic clr_any;

    assign cs_rise = cs_n & ~cs_q;
    assign clr_any = ~wp_n | wrdi | consume | soft_rst;

    always_ff @(posedge clk) begin
        if (por) begin
            cs_q  <= 1'b1;
            armed <= 1'b0;
            wel   <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (soft_rst || cs_rise) begin
                armed <= 1'b0;
            end else if (wren_done) begin
                armed <= 1'b1;
            end
            if (clr_any) begin
                wel <= 1'b0;
            end else if (cs_rise && armed) begin
                wel <= 1'b1;
            end
        end
    end

    // R5
    wel_held_low_chk: assert property (@(posedge clk) disable iff (por)
        !wp_n |=> !wel);

    // R3
    wel_set_on_cs_rise_chk: assert property (@(posedge clk) disable iff (por)
        $rose(wel) |-> ($past(cs_n) && !$past(cs_n, 2)));

endmodule

// File: rtl/wprot_cycle_timer.sv
module wprot_cycle_timer #(
    parameter int CYCLE_CLKS = 20
) (
    input  logic clk,
    input  logic por,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLE_CLKS - 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (por) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= LOAD;
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    // R10
    no_restart_busy_chk: assert property (@(posedge clk) disable iff (por)
        start |-> !busy);

    // R9
    remain_bound_chk: assert property (@(posedge clk) disable iff (por)
        busy |-> (remain <= LOAD));

endmodule

// File: rtl/wprot_arbiter.sv
module wprot_arbiter
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              wrsr_commit,
    input  logic              write_commit,
    input  logic [ADDR_W-1:0] write_addr,
    input  prot_lvl_e         lvl,
    input  logic              wel,
    input  logic              wp_n,
    input  logic              busy,
    output verdict_t          verdict
);

    logic permit;
    logic locked;
    logic seen;

    assign permit = wp_n & wel & ~busy;
    assign locked = region_locked(lvl, write_addr[ADDR_W-1 -: 2]);
    assign seen   = (wrsr_commit | write_commit) & ~busy;

    always_comb begin
        verdict.acc_sr = wrsr_commit & permit;
        verdict.acc_wr = ~wrsr_commit & write_commit & permit & ~locked;
        verdict.rej    = seen & ~(verdict.acc_sr | verdict.acc_wr);
    end

endmodule

// File: rtl/eeprom_wprot_ctrl.sv
module eeprom_wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int CYCLE_CLKS = 20
) (
    input  logic              clk,
    input  logic              por,
    input  logic              soft_rst,
    input  logic              wp_n,
    input  logic              cs_n,
    input  logic              wren_done,
    input  logic              wrdi,
    input  logic              wrsr_commit,
    input  logic [7:0]        wrsr_data,
    input  logic              write_commit,
    input  logic [ADDR_W-1:0] write_addr,
    output logic [7:0]        status_byte,
    output logic              grant,
    output logic              deny,
    output logic              busy
);

    verdict_t  verdict;
    prot_lvl_e lvl_q;
    logic      wel;
    logic      accept;
    status_t   stat;

    assign accept = verdict.acc_wr | verdict.acc_sr;

    wprot_enable_latch latch_i (
        .clk       (clk),
        .por       (por),
        .soft_rst  (soft_rst),
        .wp_n      (wp_n),
        .cs_n      (cs_n),
        .wren_done (wren_done),
        .wrdi      (wrdi),
        .consume   (accept),
        .wel       (wel)
    );

    wprot_arbiter #(.ADDR_W(ADDR_W)) arb_i (
        .wrsr_commit  (wrsr_commit),
        .write_commit (write_commit),
        .write_addr   (write_addr),
        .lvl          (lvl_q),
        .wel          (wel),
        .wp_n         (wp_n),
        .busy         (busy),
        .verdict      (verdict)
    );

    wprot_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) timer_i (
        .clk   (clk),
        .por   (por),
        .start (accept),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (por) begin
            lvl_q <= PROT_NONE;
            grant <= 1'b0;
            deny  <= 1'b0;
        end else begin
            if (verdict.acc_sr) begin
                lvl_q <= prot_lvl_e'(wrsr_data[STAT_LVL_LSB +: 2]);
            end
            grant <= accept;
            deny  <= verdict.rej;
        end
    end

    assign stat        = pack_status(lvl_q, wel, busy);
    assign status_byte = stat;

    // R7
    grant_deny_excl_chk: assert property (@(posedge clk) disable iff (por)
        !(grant && deny));

    // R7
    grant_side_effects_chk: assert property (@(posedge clk) disable iff (por)
        grant |-> (busy && !wel));

    // R8
    lvl_hold_chk: assert property (@(posedge clk) disable iff (por)
        !verdict.acc_sr |=> $stable(lvl_q));

    // R5
    wp_blocks_grant_chk: assert property (@(posedge clk) disable iff (por)
        ((write_commit || wrsr_commit) && !wp_n) |=> !grant);

endmodule

// File: tb/eeprom_wprot_ctrl_tb_top.sv
module eeprom_wprot_ctrl_tb_top;

    localparam int AW  = 9;
    localparam int CYC = 20;

    logic          clk = 1'b0;
    logic          por = 1'b1;
    logic          soft_rst = 1'b0;
    logic          wp_n = 1'b1;
    logic          cs_n = 1'b1;
    logic          wren_done = 1'b0;
    logic          wrdi = 1'b0;
    logic          wrsr_commit = 1'b0;
    logic [7:0]    wrsr_data = 8'h00;
    logic          write_commit = 1'b0;
    logic [AW-1:0] write_addr = '0;
    logic [7:0]    status_byte;
    logic          grant;
    logic          deny;
    logic          busy;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference state
    int m_wel = 0, m_lvl = 0, m_left = 0, m_arm = 0, m_prev_cs = 1, m_g = 0, m_d = 0;

    always #10 clk = ~clk;

    eeprom_wprot_ctrl #(.ADDR_W(AW), .CYCLE_CLKS(CYC)) dut_i (
        .clk(clk), .por(por), .soft_rst(soft_rst), .wp_n(wp_n), .cs_n(cs_n),
        .wren_done(wren_done), .wrdi(wrdi), .wrsr_commit(wrsr_commit),
        .wrsr_data(wrsr_data), .write_commit(write_commit), .write_addr(write_addr),
        .status_byte(status_byte), .grant(grant), .deny(deny), .busy(busy)
    );

    function automatic bit locked_ref(int lvl, int addr);
        if (lvl == 0) return 0;
        if (lvl == 1) return addr >= 384;
        if (lvl == 2) return addr >= 256;
        return 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model, stepped on each edge, compared mid-cycle
    always @(posedge clk) begin
        int  is_busy, rise, acc_sr, acc_wr, seen;
        if (por) begin
            m_wel = 0; m_lvl = 0; m_left = 0; m_arm = 0; m_prev_cs = 1; m_g = 0; m_d = 0;
        end else begin
            is_busy = (m_left > 0);
            rise    = (cs_n && !m_prev_cs);
            seen    = (wrsr_commit || write_commit) && !is_busy;
            acc_sr  = wrsr_commit && !is_busy && wp_n && m_wel;
            acc_wr  = !wrsr_commit && write_commit && !is_busy && wp_n && m_wel
                      && !locked_ref(m_lvl, int'(write_addr));
            m_g = acc_sr || acc_wr;
            m_d = seen && !m_g;
            if (m_g) m_left = CYC;
            else if (m_left > 0) m_left--;
            if (!wp_n || wrdi || m_g || soft_rst) m_wel = 0;
            else if (rise && m_arm) m_wel = 1;
            if (soft_rst || rise) m_arm = 0;
            else if (wren_done) m_arm = 1;
            if (acc_sr) m_lvl = int'(wrsr_data[3:2]);
            m_prev_cs = cs_n;
        end
        #5;
        if (!done) begin
            chk({cur_req, " status"}, int'(status_byte),
                (m_lvl << 2) | (m_wel << 1) | ((m_left > 0) ? 1 : 0));
            chk({cur_req, " grant"}, int'(grant), m_g);
            chk({cur_req, " deny"}, int'(deny), m_d);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_wren();
        step(); cs_n = 1'b0;
        step(); wren_done = 1'b1;
        step(); wren_done = 1'b0; cs_n = 1'b1;
        step();
    endtask

    task automatic do_write(int addr);
        step(); write_commit = 1'b1; write_addr = AW'(addr);
        step(); write_commit = 1'b0;
    endtask

    task automatic do_wrsr(logic [7:0] d);
        step(); wrsr_commit = 1'b1; wrsr_data = d;
        step(); wrsr_commit = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) step();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) step();
        por = 1'b0;
        step();
        cur_req = "R2";
        chk("R2 reset status", int'(status_byte), 8'h00);
        chk("R1 spare bits zero", int'(status_byte[7:4]), 0);

        // R3: enable held while chip select stays low
        cur_req = "R3";
        step(); cs_n = 1'b0;
        step(); wren_done = 1'b1;
        step(); wren_done = 1'b0;
        repeat (4) step();
        chk("R3 no set with cs low", int'(status_byte[1]), 0);
        cs_n = 1'b1;
        step(); step();
        chk("R3 set after cs rise", int'(status_byte), 8'h02);

        // R4: disable
        cur_req = "R4";
        wrdi = 1'b1; step(); wrdi = 1'b0; step();
        chk("R4 wrdi clears", int'(status_byte[1]), 0);

        // R7 / R9: granted write and cycle length
        cur_req = "R7";
        do_wren();
        do_write(9'h050);
        chk("R7 grant pulse", int'(grant), 1);
        chk("R7 latch cleared", int'(status_byte[1]), 0);
        cur_req = "R9";
        n = 0;
        while (busy) begin n++; step(); end
        chk("R9 cycle length", n, CYC);

        // R10: commit during busy ignored
        cur_req = "R10";
        do_wren();
        do_write(9'h010);
        do_write(9'h020);
        chk("R10 no grant while busy", int'(grant), 0);
        chk("R10 no deny while busy", int'(deny), 0);
        do_wrsr(8'h0C);
        chk("R10 lvl unchanged", int'(status_byte[3:2]), 0);
        wait_idle();

        // R8: status write sets quarter protection
        cur_req = "R8";
        do_wren();
        do_wrsr(8'h04);
        chk("R8 status grant", int'(grant), 1);
        wait_idle();
        chk("R8 level quarter", int'(status_byte), 8'h04);

        // R6: boundaries
        cur_req = "R6";
        do_wren(); do_write(9'h180);
        chk("R6 0x180 locked at 01", int'(deny), 1);
        chk("R7 latch kept on deny", int'(status_byte[1]), 1);
        do_write(9'h17F);
        chk("R6 0x17F open at 01", int'(grant), 1);
        wait_idle();
        do_wren(); do_wrsr(8'h08); wait_idle();
        do_wren(); do_write(9'h100);
        chk("R6 0x100 locked at 10", int'(deny), 1);
        do_write(9'h0FF);
        chk("R6 0x0FF open at 10", int'(grant), 1);
        wait_idle();
        do_wren(); do_wrsr(8'hFC); wait_idle();
        chk("R8 level all", int'(status_byte), 8'h0C);
        do_wren(); do_write(9'h000);
        chk("R6 0x000 locked at 11", int'(deny), 1);
        cur_req = "R8";
        do_wrsr(8'h00);
        chk("R8 status write under full lock", int'(grant), 1);
        wait_idle();

        // R5: protect pin
        cur_req = "R5";
        do_wren();
        wp_n = 1'b0; step();
        chk("R5 latch dropped", int'(status_byte[1]), 0);
        do_wren();
        chk("R5 no set while wp low", int'(status_byte[1]), 0);
        do_write(9'h000);
        chk("R5 deny while wp low", int'(deny), 1);
        wp_n = 1'b1;

        // R9: protect-pin fall does not abort
        cur_req = "R9";
        do_wren(); do_write(9'h033);
        step(); wp_n = 1'b0;
        n = 2;
        step();
        while (busy) begin n++; step(); end
        chk("R9 wp fall keeps cycle", n, CYC);
        wp_n = 1'b1;

        // R2: soft reset keeps the level
        cur_req = "R2";
        do_wren(); do_wrsr(8'h08); wait_idle();
        do_wren();
        soft_rst = 1'b1; step(); soft_rst = 1'b0; step();
        chk("R2 soft keeps level", int'(status_byte), 8'h08);

        // R11: clear beats set
        cur_req = "R11";
        step(); cs_n = 1'b0;
        step(); wren_done = 1'b1;
        step(); wren_done = 1'b0; cs_n = 1'b1; wrdi = 1'b1;
        step(); wrdi = 1'b0;
        step();
        chk("R11 clear wins", int'(status_byte[1]), 0);

        // R2: power-on clears the level
        cur_req = "R2";
        por = 1'b1; step(); step(); por = 1'b0; step();
        chk("R2 por clears all", int'(status_byte), 8'h00);

        repeat (3) step();
        finish_run();
    end

endmodule